// File: doc/BRIEF.md
# SD SPI Block Read Receiver

This block takes over the byte stream from a memory card on an SPI link once a read command has been accepted. It is started with a block count and a block size. For each block it watches the incoming bytes until the card stops sending the idle value, checks that the first non-idle byte is the data start marker, and streams the payload bytes out as they arrive. It then takes the two check bytes that follow the payload and compares them against a CRC it has computed over that payload.

If every block passes, the block repeats this until the count is used up, then pulses `done_o` with all error flags low. Any fault ends the transfer at once: a wrong marker byte, a CRC mismatch, or a card that stays idle for too long. The block then pulses `done_o` and raises exactly one of three flags. A 16-byte register readout is handled as a transfer with a count of one and a size of 16.

The block does not generate SPI clocks and does not store data. `busy_o` tells the SPI shifter that bytes are wanted. The shifter hands each received byte over with a one-cycle `rx_valid_i`. Payload bytes leave on `out_valid_o`/`out_data_o` for a downstream sink.

Top module: `sd_blk_rx`

## Requirements
- R1: After reset, `busy_o`, `out_valid_o`, `out_last_o`, `done_o`, `crc_err_o`, `tok_err_o` and `timeout_o` are all low.
- R2: While looking for a block start, every received 0xFF byte is skipped and produces no output. The first received byte that is not 0xFF decides how the block proceeds.
- R3: A first non-0xFF byte of 0xFE starts a data block. Any other non-0xFF value ends the transfer: `busy_o` goes low, `done_o` pulses, and `tok_err_o` is set.
- R4: After the start byte, exactly `blk_size_i` bytes are streamed out. Each appears on `out_data_o` with `out_valid_o` high in the cycle after it is accepted. A size of 0 streams nothing and moves straight on to the check bytes.
- R5: `out_last_o` is high together with the final payload byte of each block, and low with every other byte.
- R6: The two bytes after the payload are the CRC, high byte first. The CRC uses polynomial 0x1021, an initial value of 0 and MSB-first processing over the payload only; the nine bytes "123456789" give 0x31C3. On a mismatch the transfer stops with `crc_err_o` set and `done_o` pulsed.
- R7: When a block passes its CRC and more blocks remain, the block keeps `busy_o` high and looks for the next start byte. After the last block it pulses `done_o` with no flag set.
- R8: If POLL_LIMIT consecutive 0xFF bytes arrive while looking for a start, the transfer ends with `timeout_o` set and `done_o` pulsed. A 0xFE arriving right after POLL_LIMIT-1 idle bytes still starts the block.
- R9: A start with a block count of 0 pulses `done_o` in the next cycle, raises no flag, and never asserts `busy_o`. `start_i` is ignored while `busy_o` is high.
- R10: At most one error flag is high. Flags hold their value until the next accepted start, which clears them. Bytes received while idle produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (accepted only when idle) |
| blk_cnt_i | input | CNT_W | Number of blocks to receive |
| blk_size_i | input | BLK_W | Payload bytes per block |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| busy_o | output | 1 | Transfer in progress; bytes are wanted |
| out_valid_o | output | 1 | Payload byte valid |
| out_data_o | output | 8 | Payload byte |
| out_last_o | output | 1 | Final payload byte of a block |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| crc_err_o | output | 1 | Transfer ended on a CRC mismatch |
| tok_err_o | output | 1 | Transfer ended on a bad start byte |
| timeout_o | output | 1 | Transfer ended with no start byte in time |

## Verification
Two functions can land in the same cycle: the idle-poll limit running out, and a start byte being recognised. The race is provoked by sending POLL_LIMIT-1 idle bytes followed by 0xFE. The run is judged good when the block streams the payload and finishes with no timeout. The complementary case is one more idle byte in place of the marker, which must give a timeout and nothing else. A second coincidence is the final payload byte: in one cycle it must both carry `out_last_o` and enter the CRC. This is judged with known vectors whose check value only matches when that last byte is included.

// File: rtl/sd_blk_rx_pkg.sv
package sd_blk_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_CRC_HI,
    ST_CRC_LO
  } rx_state_e;

  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam logic [7:0] START_BYTE = 8'hFE;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
endpackage

// File: rtl/sd_crc16_step.sv
module sd_crc16_step #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic [15:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  always_comb begin
    logic [15:0] c;
    c = crc_i ^ {data_i, 8'h00};
    for (int k = 0; k < 8; k++) begin
      c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/sd_poll_timer.sv
module sd_poll_timer #(
  parameter int LIMIT = 3000000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(LIMIT));
endmodule

// File: rtl/sd_down_cnt.sv
module sd_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         is_one_o
);
  logic [W-1:0] cnt_q;

  assign is_one_o = (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sd_blk_rx.sv
module sd_blk_rx
  import sd_blk_rx_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BLK_W      = 12,
  parameter int POLL_LIMIT = 3000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [BLK_W-1:0] blk_size_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  output logic             done_o,
  output logic             crc_err_o,
  output logic             tok_err_o,
  output logic             timeout_o
);
  rx_state_e   state_q;
  logic [15:0] crc_q, crc_nxt;
  logic [7:0]  crc_hi_q;
  logic        out_valid_q, out_last_q, done_q;
  logic [7:0]  out_data_q;
  logic        crc_err_q, tok_err_q, timeout_q;

  logic acc, is_ff, is_start, poll_expire, byte_last, blk_last, crc_ok;

  assign acc      = rx_valid_i && (state_q != ST_IDLE);
  assign is_ff    = (rx_data_i == IDLE_BYTE);
  assign is_start = (rx_data_i == START_BYTE);
  assign crc_ok   = ({crc_hi_q, rx_data_i} == crc_q);

  sd_crc16_step #(.POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .data_i(rx_data_i),
    .crc_o (crc_nxt)
  );

  sd_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != ST_HUNT),
    .tick_i  ((state_q == ST_HUNT) && acc && is_ff),
    .expire_o(poll_expire)
  );

  sd_down_cnt #(.W(BLK_W)) u_byte_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    ((state_q == ST_HUNT) && acc && is_start),
    .load_val_i(blk_size_i),
    .dec_i     ((state_q == ST_DATA) && acc),
    .is_one_o  (byte_last)
  );

  sd_down_cnt #(.W(CNT_W)) u_blk_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    ((state_q == ST_IDLE) && start_i),
    .load_val_i(blk_cnt_i),
    .dec_i     ((state_q == ST_CRC_LO) && acc && crc_ok),
    .is_one_o  (blk_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      crc_q       <= '0;
      crc_hi_q    <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
      done_q      <= 1'b0;
      crc_err_q   <= 1'b0;
      tok_err_q   <= 1'b0;
      timeout_q   <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      done_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          crc_err_q <= 1'b0;
          tok_err_q <= 1'b0;
          timeout_q <= 1'b0;
          if (blk_cnt_i == '0) done_q  <= 1'b1;
          else                 state_q <= ST_HUNT;
        end
        ST_HUNT: if (acc) begin
          if (is_ff) begin
            if (poll_expire) begin
              timeout_q <= 1'b1;
              done_q    <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end else if (is_start) begin
            crc_q   <= '0;
            state_q <= (blk_size_i == '0) ? ST_CRC_HI : ST_DATA;
          end else begin
            tok_err_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_DATA: if (acc) begin
          crc_q       <= crc_nxt;
          out_valid_q <= 1'b1;
          out_data_q  <= rx_data_i;
          out_last_q  <= byte_last;
          if (byte_last) state_q <= ST_CRC_HI;
        end
        ST_CRC_HI: if (acc) begin
          crc_hi_q <= rx_data_i;
          state_q  <= ST_CRC_LO;
        end
        ST_CRC_LO: if (acc) begin
          if (!crc_ok) begin
            crc_err_q <= 1'b1;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (blk_last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_HUNT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign out_last_o  = out_last_q;
  assign done_o      = done_q;
  assign crc_err_o   = crc_err_q;
  assign tok_err_o   = tok_err_q;
  assign timeout_o   = timeout_q;

  p_stream_from_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(state_q) == ST_DATA));
  p_last_with_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  p_tok_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tok_err_o) |-> ($past(rx_data_i) != IDLE_BYTE && $past(rx_data_i) != START_BYTE));
  p_crc_err_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_o) |-> ($past(state_q) == ST_CRC_LO));
  p_timeout_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(state_q) == ST_HUNT && $past(rx_data_i) == IDLE_BYTE));
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_busy_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !rx_valid_i) |=> busy_o);
  p_one_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({crc_err_o, tok_err_o, timeout_o}));
endmodule

// File: tb/tb_sd_blk_rx.sv
module tb_sd_blk_rx;
  localparam int CNT_W = 8;
  localparam int BLK_W = 10;
  localparam int PL    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] blk_cnt = '0;
  logic [BLK_W-1:0] blk_size = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'hFF;
  logic busy, out_valid, out_last, done, crc_err, tok_err, timeout;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got_d[$], exp_d[$];
  logic       got_l[$], exp_l[$];

  always #2 clk = ~clk;

  sd_blk_rx #(.CNT_W(CNT_W), .BLK_W(BLK_W), .POLL_LIMIT(PL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_cnt_i(blk_cnt),
    .blk_size_i(blk_size), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .busy_o(busy), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_last_o(out_last), .done_o(done), .crc_err_o(crc_err),
    .tok_err_o(tok_err), .timeout_o(timeout));

  always @(negedge clk) if (out_valid) begin
    got_d.push_back(out_data);
    got_l.push_back(out_last);
  end

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_q();
    got_d.delete(); got_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  task automatic check_stream(input string req);
    int mism = 0;
    chk(got_d.size() == exp_d.size(), req, got_d.size(), exp_d.size());
    if (got_d.size() == exp_d.size())
      foreach (exp_d[i]) if (got_d[i] !== exp_d[i] || got_l[i] !== exp_l[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
  endtask

  task automatic quiet();
    @(negedge clk); rx_valid = 1'b0; rx_data = 8'hFF;
  endtask

  task automatic start_rx(input int cnt, input int size);
    @(negedge clk); start = 1'b1; blk_cnt = CNT_W'(cnt); blk_size = BLK_W'(size);
    @(negedge clk); start = 1'b0;
  endtask

  // base 0 gives ASCII "123..."; bad flips the CRC low byte
  task automatic send_block(input int nff, input int size, input int base, input bit bad);
    logic [15:0] c = 16'h0;
    for (int i = 0; i < nff; i++) send(8'hFF);
    send(8'hFE);
    for (int i = 0; i < size; i++) begin
      logic [7:0] b;
      b = (base == 0) ? 8'(8'h31 + i) : 8'(base * 37 + i * 13 + 5);
      c = crc_ref(c, b);
      exp_d.push_back(b);
      exp_l.push_back(i == size - 1);
      send(b);
    end
    send(c[15:8]);
    send(bad ? (c[7:0] ^ 8'h01) : c[7:0]);
  endtask

  task automatic t_reset();
    chk({busy, out_valid, out_last, done, crc_err, tok_err, timeout} == 7'b0, "R1",
        {busy, out_valid, out_last, done, crc_err, tok_err, timeout}, 0);
  endtask

  task automatic t_single();
    logic [15:0] c = 16'h0;
    for (int i = 0; i < 9; i++) c = crc_ref(c, 8'(8'h31 + i));
    chk(c == 16'h31C3, "R6", c, 16'h31C3);
    clear_q();
    start_rx(1, 9);
    send(8'hFF); send(8'hFF); quiet();
    chk(busy && got_d.size() == 0, "R2", got_d.size(), 0);
    send_block(1, 9, 0, 0);
    quiet();
    chk(done && !crc_err && !tok_err && !timeout, "R6", {done, crc_err, tok_err, timeout}, 4'b1000);
    check_stream("R5");
  endtask

  task automatic t_multi();
    clear_q();
    start_rx(3, 5);
    send_block(0, 5, 3, 0);
    quiet();
    chk(busy && !done, "R7", {busy, done}, 2'b10);
    send_block(4, 5, 7, 0);
    send_block(2, 5, 11, 0);
    quiet();
    chk(done && !crc_err && !tok_err && !timeout && !busy, "R7",
        {done, crc_err, tok_err, timeout, busy}, 5'b10000);
    check_stream("R4");
  endtask

  task automatic t_crc_err();
    clear_q();
    start_rx(2, 6);
    send_block(1, 6, 5, 1);
    quiet();
    chk(done && crc_err && !busy, "R6", {done, crc_err, busy}, 3'b110);
    send(8'hFE); send(8'h12); send(8'h34); quiet(); quiet();
    chk(crc_err && !done, "R10", {crc_err, done}, 2'b10);
    check_stream("R10");
  endtask

  task automatic t_tok_err();
    clear_q();
    start_rx(1, 4);
    chk(!crc_err, "R10", crc_err, 0);
    send(8'hFF); send(8'hFF); send(8'hFC); quiet();
    chk(done && tok_err && !crc_err && !busy, "R3", {done, tok_err, crc_err, busy}, 4'b1100);
    check_stream("R3");
  endtask

  task automatic t_timeout();
    clear_q();
    start_rx(1, 4);
    for (int i = 0; i < PL - 1; i++) send(8'hFF);
    quiet();
    chk(busy && !timeout, "R8", {busy, timeout}, 2'b10);
    send(8'hFF); quiet();
    chk(done && timeout && !tok_err && !busy, "R8", {done, timeout, tok_err, busy}, 4'b1100);
  endtask

  task automatic t_race();
    clear_q();
    start_rx(1, 2);
    send_block(PL - 1, 2, 9, 0);
    quiet();
    chk(done && !timeout && !crc_err, "R8", {done, timeout, crc_err}, 3'b100);
    check_stream("R8");
  endtask

  task automatic t_zero_cnt();
    @(negedge clk); start = 1'b1; blk_cnt = '0; blk_size = 10'd4;
    @(negedge clk); start = 1'b0;
    chk(done && !busy && !timeout && !crc_err && !tok_err, "R9",
        {done, busy, timeout, crc_err, tok_err}, 5'b10000);
  endtask

  task automatic t_start_busy();
    clear_q();
    start_rx(1, 4);
    @(negedge clk); start = 1'b1; blk_cnt = '0;
    @(negedge clk); start = 1'b0;
    chk(busy && !done, "R9", {busy, done}, 2'b10);
    blk_size = 10'd4;
    send_block(0, 4, 13, 0);
    quiet();
    chk(done && !crc_err, "R9", {done, crc_err}, 2'b10);
    check_stream("R9");
  endtask

  task automatic t_size0();
    clear_q();
    start_rx(1, 0);
    send(8'hFE); send(8'h00); send(8'h00); quiet();
    chk(done && !crc_err && got_d.size() == 0, "R4", {done, crc_err}, 2'b10);
  endtask

  task automatic t_reg16();
    clear_q();
    start_rx(1, 16);
    send_block(3, 16, 21, 0);
    quiet();
    chk(done && !crc_err, "R7", {done, crc_err}, 2'b10);
    check_stream("R5");
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1; t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); t_reset();
    t_single();
    t_multi();
    t_crc_err();
    t_tok_err();
    t_timeout();
    t_race();
    t_zero_cnt();
    t_start_busy();
    t_size0();
    t_reg16();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule